// File: doc/BRIEF.md
# Dual-Edge Frame Sampler

This block samples a narrow parallel input twice per period of a single system clock, once on the rising edge and once on the falling edge. The result is two samples per clock cycle without a faster clock. A free-running index counter divides time into fixed frames of `FRAME_LEN` cycles, so each frame holds `2*FRAME_LEN` samples. Rising-edge samples go into one buffer and falling-edge samples into another buffer of the same size. Each buffer is indexed by the cycle number within the frame.

Each buffer has two banks, and the banks alternate from frame to frame. A finished frame therefore stays readable for a whole frame period while the next one is being captured. The block raises a one-cycle pulse when a frame completes. A consumer then reads the completed frame through a random-access port clocked on the rising edge. Each read returns one cycle's sample pair in time order, which merges the two edge buffers into one time-ordered sequence.

Top module: `dual_edge_capture`

## Requirements
- R1: The rising-edge sample taken at the rising edge where the frame index is i is returned in the low lane `rd_data_o[DATA_W-1:0]` when pair address i of that frame is read.
- R2: The falling-edge sample taken on the falling edge that directly follows the rising edge with frame index i is returned in the high lane `rd_data_o[2*DATA_W-1:DATA_W]` of pair address i. Sample slot 2i is therefore the rising sample and slot 2i+1 the falling sample.
- R3: A frame spans exactly `FRAME_LEN` (default 100) rising edges, indexed 0 to `FRAME_LEN-1`, and yields `2*FRAME_LEN` samples. The index wraps to 0 after the last value.
- R4: `frame_done_o` is high for exactly one cycle: the cycle after the rising edge that stored a frame's last rising sample. It recurs every `FRAME_LEN` cycles.
- R5: A pair address applied to `rd_addr_i` before a rising edge is reflected on `rd_data_o` right after that edge, so the read latency is one cycle.
- R6: A completed frame stays readable unchanged from the cycle in which `frame_done_o` is high through the cycle in which `frame_done_o` is next high, even though the next frame is captured meanwhile.
- R7: While `rst_ni` is low, `frame_done_o` is low. After `rst_ni` rises, the third rising edge captures frame index 0, so the first `frame_done_o` pulse follows the 103rd rising edge (with `FRAME_LEN` = 100).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; both of its edges sample |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_i | input | DATA_W | Sampled input data |
| rd_addr_i | input | IDX_W | Pair address (frame cycle index) of the completed frame |
| frame_done_o | output | 1 | One-cycle pulse when a frame has been fully stored |
| rd_data_o | output | 2*DATA_W | Sample pair: rising sample low, falling sample high |

## Verification
Two functions fall in the same cycle here: the last read of a completed frame and the first writes of the frame after it. That cycle also carries the `frame_done_o` pulse and the bank swap. The bench provokes this by reading pair 0 in the cycle of the pulse and reading pair `FRAME_LEN-1` in the cycle of the next pulse. Meanwhile new data with a different pattern is being captured into the other bank. The check is that all `2*FRAME_LEN` samples match the pattern driven during the captured frame, lane by lane, with the pulse seen again in the last read cycle.

// File: rtl/dcap_pkg.sv
`timescale 1ns/1ps
package dcap_pkg;

  // Which clock edge a capture buffer writes on.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  // Write tag carried from the rising domain to the falling-edge buffer.
  typedef struct packed {
    logic vld;
    logic bank;
  } wr_tag_t;

endpackage

// File: rtl/dcap_rst_sync.sv
`timescale 1ns/1ps
module dcap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/dcap_frame_ctrl.sv
`timescale 1ns/1ps
module dcap_frame_ctrl #(
  parameter int FRAME_LEN = 100,
  parameter int IDX_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             cap_bank_o,
  output dcap_pkg::wr_tag_t prev_tag_o,
  output logic [IDX_W-1:0] prev_idx_o,
  output logic             rd_bank_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              bank_q, bank_d;
  logic [IDX_W-1:0]  prev_idx_q, prev_idx_d;
  dcap_pkg::wr_tag_t prev_tag_q, prev_tag_d;
  logic              rd_bank_q, rd_bank_d;
  logic              done_q, done_d;
  logic              wrap;
  logic              rd_bank_en;

  // Next-state logic
  always_comb begin
    wrap            = (idx_q == LAST);
    idx_d           = wrap ? '0 : idx_q + 1'b1;
    bank_d          = wrap ? ~bank_q : bank_q;
    prev_idx_d      = idx_q;
    prev_tag_d.vld  = 1'b1;
    prev_tag_d.bank = bank_q;
    done_d          = prev_tag_q.vld && (prev_idx_q == LAST);
    rd_bank_en      = done_d;
    rd_bank_d       = prev_tag_q.bank;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      bank_q     <= 1'b0;
      prev_idx_q <= '0;
      prev_tag_q <= '0;
      done_q     <= 1'b0;
    end else begin
      idx_q      <= idx_d;
      bank_q     <= bank_d;
      prev_idx_q <= prev_idx_d;
      prev_tag_q <= prev_tag_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_bank_q <= 1'b1;
    else if (rd_bank_en) rd_bank_q <= rd_bank_d;
  end

  assign cap_idx_o  = idx_q;
  assign cap_bank_o = bank_q;
  assign prev_tag_o = prev_tag_q;
  assign prev_idx_o = prev_idx_q;
  assign rd_bank_o  = rd_bank_q;
  assign done_o     = done_q;

  // R3: index stays inside the frame and wraps to zero
  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
  assert_idx_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == LAST) |=> (idx_q == '0));
  // R6: capture bank only swaps across a frame boundary
  assert_bank_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != LAST) |=> $stable(bank_q));
  // R4: done pulse is a single cycle
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

endmodule

// File: rtl/dcap_edge_buf.sv
`timescale 1ns/1ps
module dcap_edge_buf #(
  parameter dcap_pkg::edge_e EDGE = dcap_pkg::EDGE_RISE,
  parameter int DATA_W = 4,
  parameter int DEPTH  = 100,
  parameter int IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wbank_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rbank_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  // Two banks: one fills while the other is read.
  logic [DATA_W-1:0] mem [2][DEPTH];

  generate
    if (EDGE == dcap_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i) begin
        if (we_i) mem[wbank_i][waddr_i] <= wdata_i;
      end
    end else begin : g_fall
      always_ff @(negedge clk_i) begin
        if (we_i) mem[wbank_i][waddr_i] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    if (raddr_i <= LAST) rdata_o = mem[rbank_i][raddr_i];
    else                 rdata_o = '0;
  end

endmodule

// File: rtl/dual_edge_capture.sv
`timescale 1ns/1ps
module dual_edge_capture #(
  parameter int DATA_W    = 4,
  parameter int FRAME_LEN = 100,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   din_i,
  input  logic [IDX_W-1:0]    rd_addr_i,
  output logic                frame_done_o,
  output logic [2*DATA_W-1:0] rd_data_o
);

  localparam int SYNC_STAGES = 2;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  cap_idx;
  logic              cap_bank;
  dcap_pkg::wr_tag_t prev_tag;
  logic [IDX_W-1:0]  prev_idx;
  logic              rd_bank;
  logic              done;
  logic [DATA_W-1:0] rise_rdata;
  logic [DATA_W-1:0] fall_rdata;
  logic [2*DATA_W-1:0] rd_data_d, rd_data_q;

  dcap_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dcap_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) i_frame_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .cap_idx_o  (cap_idx),
    .cap_bank_o (cap_bank),
    .prev_tag_o (prev_tag),
    .prev_idx_o (prev_idx),
    .rd_bank_o  (rd_bank),
    .done_o     (done)
  );

  // Rising path: writes at the edge using the live index.
  dcap_edge_buf #(
    .EDGE(dcap_pkg::EDGE_RISE), .DATA_W(DATA_W), .DEPTH(FRAME_LEN), .IDX_W(IDX_W)
  ) i_rise_buf (
    .clk_i   (clk_i),
    .we_i    (rst_sync_n),
    .wbank_i (cap_bank),
    .waddr_i (cap_idx),
    .wdata_i (din_i),
    .rbank_i (rd_bank),
    .raddr_i (rd_addr_i),
    .rdata_o (rise_rdata)
  );

  // Falling path: index of the rising edge half a cycle earlier.
  dcap_edge_buf #(
    .EDGE(dcap_pkg::EDGE_FALL), .DATA_W(DATA_W), .DEPTH(FRAME_LEN), .IDX_W(IDX_W)
  ) i_fall_buf (
    .clk_i   (clk_i),
    .we_i    (prev_tag.vld),
    .wbank_i (prev_tag.bank),
    .waddr_i (prev_idx),
    .wdata_i (din_i),
    .rbank_i (rd_bank),
    .raddr_i (rd_addr_i),
    .rdata_o (fall_rdata)
  );

  // Merge in time order: rising sample in the low lane.
  always_comb begin
    rd_data_d = {fall_rdata, rise_rdata};
  end

  always_ff @(posedge clk_i) begin
    rd_data_q <= rd_data_d;
  end

  assign rd_data_o    = rd_data_q;
  assign frame_done_o = done;

  // R6: the bank being read is never the one being filled at frame end
  assert_bank_split_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done |-> (rd_bank != cap_bank));
  // R4: pulse lands one edge after the index wrapped
  assert_done_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done |-> (cap_idx == IDX_W'(1 % FRAME_LEN)));
  // R2: falling write follows a valid rising slot of the same frame
  assert_fall_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    prev_tag.vld |-> (prev_idx != cap_idx || FRAME_LEN == 1));
  // R7: no pulse during or right after reset release
  assert_reset_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !prev_tag.vld |-> !done);

endmodule

// File: tb/test_dual_edge_capture.sv
`timescale 1ns/1ps
module test_dual_edge_capture;

  localparam int DATA_W    = 4;
  localparam int FRAME_LEN = 100;
  localparam int IDX_W     = 7;
  localparam int NPAT      = 4;
  // Pattern vectors: {multiplier, offset}; sample(slot) = (slot*mul+off) ^ (slot>>3)
  localparam logic [15:0] PAT [NPAT] = '{16'h0100, 16'h0305, 16'h0709, 16'h0B02};

  logic                clk_i = 1'b0;
  logic                rst_ni;
  logic [DATA_W-1:0]   din_i;
  logic [IDX_W-1:0]    rd_addr_i;
  logic                frame_done_o;
  logic [2*DATA_W-1:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int slot   = 0;
  bit ended  = 0;

  dual_edge_capture #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) i_dual_edge_capture (
    .clk_i, .rst_ni, .din_i, .rd_addr_i, .frame_done_o, .rd_data_o
  );

  always #2.5 clk_i = ~clk_i;

  function automatic logic [DATA_W-1:0] pat_val(input int m, input int s);
    int mul = int'(PAT[m][15:8]);
    int off = int'(PAT[m][7:0]);
    return DATA_W'((s * mul + off) ^ (s >> 3));
  endfunction

  // Input changes every half period, 1.25 ns after each edge.
  initial begin
    din_i = '0;
    forever begin
      @(clk_i);
      #1.25;
      din_i = pat_val(mode, slot);
      slot  = slot + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!frame_done_o && n < 500);
  endtask

  // Starts at a sample point where frame_done_o is high.
  task automatic run_entry(input int m);
    int lows = 0;
    for (int k = 0; k < 99; k++) begin tick(); if (frame_done_o) lows++; end
    chk("R4", "pulse width", lows, 0);
    #2;
    mode = m;
    slot = 0;
    tick();
    chk("R4", "pulse period", int'(frame_done_o), 1);
    lows = 0;
    for (int k = 0; k < 99; k++) begin tick(); if (frame_done_o) lows++; end
    chk("R3", "frame length", lows, 0);
    tick();
    chk("R3", "frame end pulse", int'(frame_done_o), 1);
    for (int i = 0; i < FRAME_LEN; i++) begin
      rd_addr_i = IDX_W'(i);
      tick();
      chk("R1_R5", "rising lane", int'(rd_data_o[DATA_W-1:0]), int'(pat_val(m, 2*i)));
      chk("R2_R5", "falling lane", int'(rd_data_o[2*DATA_W-1:DATA_W]), int'(pat_val(m, 2*i+1)));
    end
    chk("R6", "readable until next pulse", int'(frame_done_o), 1);
  endtask

  initial begin
    int n;
    rst_ni    = 1'b0;
    rd_addr_i = '0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7", "done in reset", int'(frame_done_o), 0);
    end
    rst_ni = 1'b1;
    wait_done(n);
    chk("R7", "first pulse edge", n, 103);

    for (int e = 0; e < NPAT; e++) run_entry(e);

    // Reset in the middle of a frame
    for (int k = 0; k < 37; k++) tick();
    rst_ni = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7", "done in mid reset", int'(frame_done_o), 0);
    end
    rst_ni = 1'b1;
    wait_done(n);
    chk("R7", "pulse after mid reset", n, 103);
    run_entry(2);

    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule